// File: doc/BRIEF.md
# Multiplexed Address/Data SRAM Bus Master

This block is a synchronous master for an external low-power SRAM port whose 16-bit address and 16-bit data share one bidirectional bus. A host hands it one request at a time over a valid/ready handshake: a word address, write data, a two-bit byte-lane mask and a read/write flag. The master then runs one complete single-word cycle on the pins. First it puts the address on the bus with chip select and the active-low address strobe both low. It then raises the strobe so the memory latches the address, and keeps the address on the bus for a hold window. Last comes the data phase: a write-enable pulse for a write, or an output-enable window with the bus released for a read.

Each minimum timing interval of the memory is a parameter counted in system-clock cycles, rounded up from the nanosecond minimum at the chosen clock period. Where two rules bound the same phase, the phase lasts the larger of the two counts. A cycle-time counter, started when a request is accepted, keeps ready low until the minimum cycle has passed. A finished transfer is reported with a one-cycle done pulse. For a read, that pulse comes with the captured data.

The bidirectional bus is split into `bus_out`, `bus_oe` and `bus_in`, so the pad cell is placed at chip level.

Top module: `mux_sram_master`

## Requirements
- R1: After reset, the strobe, chip select, write enable and output enable are high. Both byte enables are high, `bus_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: An accepted request starts an address phase. In it, `mem_cs_n` and `mem_adv_n` are low and `bus_out` carries `req_addr` with `bus_oe` high. The strobe stays low for exactly LOW = max(T_ADV_LOW, T_ADDR_SETUP, T_CS_SETUP, 1) cycles.
- R3: After the strobe rises, chip select stays low and `bus_out` keeps the same address with `bus_oe` high for exactly HOLD = max(T_ADDR_HOLD, 1) cycles.
- R4: For a write, `mem_we_n` is low for exactly WR = max(T_WE_LOW, T_DATA_SETUP, 1) cycles, with the write data on the bus and `mem_oe_n` high throughout. `mem_we_n` and `mem_cs_n` rise on the same edge, and the bus is released on that edge.
- R5: The byte mask selects the lanes: mask bit 0 drives `mem_be_n[0]` (bits 7:0) and mask bit 1 drives `mem_be_n[1]` (bits 15:8). An enabled lane shows 0 and a masked lane shows 1. Byte enables go low only during the write-enable pulse or the output-enable window. A lane left out of a write keeps its old memory content.
- R6: For a read, the bus is released after the hold window and `mem_oe_n` is low for exactly ACC = max(T_ACCESS, 1) cycles. `bus_in` is sampled in the last of those cycles. `rsp_rdata` carries the sampled bits for enabled lanes and zeros for masked lanes.
- R7: After `mem_oe_n` rises, chip select is high and the bus is not driven for at least TURN = max(T_TURN, 1) cycles.
- R8: `rsp_done` is a single-cycle pulse. It appears LOW+HOLD+WR+1 clock samples after the accepting edge for a write, and LOW+HOLD+ACC+TURN+1 for a read.
- R9: `req_ready` is low from the accepting edge until the cycle counter has run out and the pins are idle. Two back-to-back requests are accepted exactly max(T_CYCLE, P+1) edges apart, where P is the phase total of the first request.
- R10: `bus_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Master can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with and after `rsp_done` |
| mem_adv_n | output | 1 | Active-low address-valid strobe |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte enables, bit 1 upper lane |
| bus_out | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus drive enable |
| bus_in | input | 16 | Value sensed on the shared bus |

## Verification
The bench is parameterised so that each phase length comes from a different timing rule: the setup count, not the strobe width, sets the strobe width, and the data-setup count is not the one that sets the write pulse. A design that took the wrong maximum would therefore produce a phase of the wrong length. A bench-side memory model latches the address from the pins and writes only the lanes whose enables are low. Partial-mask writes followed by full reads expose a lane-swap or a lane that is written when masked; masked-lane reads expose stale bits left in the read data. Back-to-back write and read streams check the cycle-time gap exactly, so an off-by-one in the counter load or a ready that returns too early shows up as a wrong accept spacing. A monitor also measures how long the bus stays undriven after each read, and would catch a design that drives the bus while the memory's outputs are still on.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_HOLD  = 3'd2,
    PH_WDATA = 3'd3,
    PH_RACC  = 3'd4,
    PH_TURN  = 3'd5
  } phase_t;

  // Length of a phase bound by up to three minimum-time counts, never zero.
  function automatic int unsigned phase_cycles(input int unsigned a,
                                               input int unsigned b,
                                               input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m == 0) ? 1 : m;
  endfunction

  // Cycle count for a nanosecond minimum at a clock period given in ps.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/mxs_phase_seq.sv
module mxs_phase_seq
  import mxs_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned LEN_ADDR = 2,
  parameter int unsigned LEN_HOLD = 1,
  parameter int unsigned LEN_WR   = 3,
  parameter int unsigned LEN_ACC  = 3,
  parameter int unsigned LEN_TURN = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   is_write,
  output phase_t phase,
  output logic   sample,
  output logic   finish
);

  logic [CW-1:0] cnt;
  phase_t        nxt;
  logic          last;

  assign last = (cnt == '0);

  function automatic logic [CW-1:0] load_for(input phase_t p);
    case (p)
      PH_ADDR:  return CW'(LEN_ADDR - 1);
      PH_HOLD:  return CW'(LEN_HOLD - 1);
      PH_WDATA: return CW'(LEN_WR - 1);
      PH_RACC:  return CW'(LEN_ACC - 1);
      PH_TURN:  return CW'(LEN_TURN - 1);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE:  if (start) nxt = PH_ADDR;
      PH_ADDR:  if (last)  nxt = PH_HOLD;
      PH_HOLD:  if (last)  nxt = is_write ? PH_WDATA : PH_RACC;
      PH_WDATA: if (last)  nxt = PH_IDLE;
      PH_RACC:  if (last)  nxt = PH_TURN;
      PH_TURN:  if (last)  nxt = PH_IDLE;
      default:             nxt = PH_IDLE;
    endcase
  end

  assign sample = (phase == PH_RACC) && last;
  assign finish = ((phase == PH_WDATA) || (phase == PH_TURN)) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= nxt;
      if (nxt != phase) cnt <= load_for(nxt);
      else if (!last)   cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/mxs_cycle_guard.sv
module mxs_cycle_guard #(
  parameter int unsigned CW     = 8,
  parameter int unsigned LEN_WC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  logic [CW-1:0] left;

  assign expired = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left <= '0;
    else if (start)    left <= CW'(LEN_WC - 1);
    else if (!expired) left <= left - 1'b1;
  end

endmodule

// File: rtl/mxs_pin_ctl.sv
module mxs_pin_ctl
  import mxs_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          sample,
  input  logic          finish,
  input  logic [DW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic [NB-1:0] mask_q,
  input  logic [DW-1:0] bus_in,
  output logic          adv_n,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [NB-1:0] be_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] lane_bits;
  logic          lanes_on;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{mask_q[g]}};
  end

  assign lanes_on = (phase == PH_WDATA) || (phase == PH_RACC);
  assign adv_n    = (phase != PH_ADDR);
  assign cs_n     = !((phase == PH_ADDR) || (phase == PH_HOLD) || lanes_on);
  assign we_n     = (phase != PH_WDATA);
  assign oe_n     = (phase != PH_RACC);
  assign be_n     = lanes_on ? ~mask_q : '1;
  assign bus_oe   = (phase == PH_ADDR) || (phase == PH_HOLD) || (phase == PH_WDATA);
  assign bus_out  = (phase == PH_WDATA) ? wdata_q : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (sample) rdata <= bus_in & lane_bits;
    end
  end

endmodule

// File: rtl/mux_sram_master.sv
module mux_sram_master
  import mxs_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned CW           = 8,
  parameter int unsigned T_ADV_LOW    = 2,
  parameter int unsigned T_ADDR_SETUP = 2,
  parameter int unsigned T_CS_SETUP   = 1,
  parameter int unsigned T_ADDR_HOLD  = 1,
  parameter int unsigned T_WE_LOW     = 3,
  parameter int unsigned T_DATA_SETUP = 2,
  parameter int unsigned T_ACCESS     = 3,
  parameter int unsigned T_TURN       = 1,
  parameter int unsigned T_CYCLE      = 7,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_mask,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_adv_n,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [NB-1:0] mem_be_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in
);

  localparam int unsigned LEN_ADDR = phase_cycles(T_ADV_LOW, T_ADDR_SETUP, T_CS_SETUP);
  localparam int unsigned LEN_HOLD = phase_cycles(T_ADDR_HOLD, 0, 0);
  localparam int unsigned LEN_WR   = phase_cycles(T_WE_LOW, T_DATA_SETUP, 0);
  localparam int unsigned LEN_ACC  = phase_cycles(T_ACCESS, 0, 0);
  localparam int unsigned LEN_TURN = phase_cycles(T_TURN, 0, 0);
  localparam int unsigned LEN_WC   = phase_cycles(T_CYCLE, 0, 0);

  phase_t        phase;
  logic          sample_w;
  logic          finish_w;
  logic          expired_w;
  logic          accept_w;
  logic          write_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] mask_q;

  assign req_ready = (phase == PH_IDLE) && expired_w;
  assign accept_w  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept_w) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  mxs_phase_seq #(
    .CW(CW), .LEN_ADDR(LEN_ADDR), .LEN_HOLD(LEN_HOLD),
    .LEN_WR(LEN_WR), .LEN_ACC(LEN_ACC), .LEN_TURN(LEN_TURN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept_w), .is_write(write_q),
    .phase(phase), .sample(sample_w), .finish(finish_w)
  );

  mxs_cycle_guard #(.CW(CW), .LEN_WC(LEN_WC)) u_guard (
    .clk(clk), .rst_n(rst_n), .start(accept_w), .expired(expired_w)
  );

  mxs_pin_ctl #(.DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .sample(sample_w),
    .finish(finish_w), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q),
    .bus_in(bus_in), .adv_n(mem_adv_n), .cs_n(mem_cs_n), .we_n(mem_we_n),
    .oe_n(mem_oe_n), .be_n(mem_be_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .done(rsp_done), .rdata(rsp_rdata)
  );

endmodule

// File: rtl/mxs_checker.sv
module mxs_checker #(
  parameter int unsigned DW       = 16,
  parameter int unsigned NB       = 2,
  parameter int unsigned LEN_ADDR = 2,
  parameter int unsigned LEN_WR   = 3,
  parameter int unsigned LEN_TURN = 1,
  parameter int unsigned LEN_WC   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_n,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [NB-1:0] be_n,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic          done,
  input logic          ready,
  input logic          accept
);

  logic [15:0] adv_run, we_run, since_acc, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_run   <= '0;
      we_run    <= '0;
      since_acc <= '1;
      since_oe  <= '1;
    end else begin
      adv_run   <= !adv_n ? ((adv_run == '1) ? adv_run : adv_run + 1'b1) : '0;
      we_run    <= !we_n  ? ((we_run  == '1) ? we_run  : we_run  + 1'b1) : '0;
      since_acc <= accept ? 16'd1 : ((since_acc == '1) ? since_acc : since_acc + 1'b1);
      since_oe  <= !oe_n  ? '0 : ((since_oe == '1) ? since_oe : since_oe + 1'b1);
    end
  end

  p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_n) |-> (adv_run >= 16'(LEN_ADDR)));

  p_cs_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> (!cs_n && bus_oe));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_n) |-> (bus_oe && !cs_n && (bus_out == $past(bus_out))));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run >= 16'(LEN_WR)));

  p_oe_off_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_write_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($rose(cs_n) && !bus_oe));

  p_lane_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (be_n != '1) |-> (!we_n || !oe_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (since_oe >= 16'(LEN_TURN)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  p_cycle_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (since_acc >= 16'(LEN_WC)));

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && !oe_n));

endmodule

bind mux_sram_master mxs_checker #(
  .DW(DW), .NB(NB), .LEN_ADDR(LEN_ADDR), .LEN_WR(LEN_WR),
  .LEN_TURN(LEN_TURN), .LEN_WC(LEN_WC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adv_n(mem_adv_n), .cs_n(mem_cs_n),
  .we_n(mem_we_n), .oe_n(mem_oe_n), .be_n(mem_be_n), .bus_out(bus_out),
  .bus_oe(bus_oe), .done(rsp_done), .ready(req_ready), .accept(accept_w)
);

// File: tb/mux_sram_master_test.sv
module mux_sram_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int A_LOW = 2, A_SET = 3, A_CSS = 1, A_HOLD = 2;
  localparam int W_LOW = 3, W_SET = 2, R_ACC = 4, R_TURN = 2, CYC = 10;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_LOW  = mx(mx(A_LOW, A_SET), mx(A_CSS, 1));
  localparam int E_HOLD = mx(A_HOLD, 1);
  localparam int E_WR   = mx(mx(W_LOW, W_SET), 1);
  localparam int E_ACC  = mx(R_ACC, 1);
  localparam int E_TURN = mx(R_TURN, 1);
  localparam int E_WC   = mx(CYC, 1);
  localparam int WR_PH  = E_LOW + E_HOLD + E_WR;
  localparam int RD_PH  = E_LOW + E_HOLD + E_ACC + E_TURN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_done, mem_adv_n, mem_cs_n, mem_we_n, mem_oe_n, bus_oe;
  logic [15:0] rsp_rdata, bus_out, bus_in;
  logic [1:0]  mem_be_n;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] model_mem [256];
  logic [15:0] shadow [256];
  logic [15:0] lat_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign bus_in = (!mem_cs_n && !mem_oe_n) ? model_mem[lat_addr[7:0]] : 16'h0000;

  mux_sram_master #(
    .T_ADV_LOW(A_LOW), .T_ADDR_SETUP(A_SET), .T_CS_SETUP(A_CSS),
    .T_ADDR_HOLD(A_HOLD), .T_WE_LOW(W_LOW), .T_DATA_SETUP(W_SET),
    .T_ACCESS(R_ACC), .T_TURN(R_TURN), .T_CYCLE(CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Pin monitor and memory model, all sampled on the falling edge.
  logic p_adv = 1, p_we = 1, p_oe = 1, p_done = 0, in_hold = 0, turn_on = 0;
  logic [15:0] p_bus = '0;
  logic [1:0]  p_be = 2'b11;
  int adv_run = 0, hold_run = 0, we_run = 0, oe_run = 0, turn_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_adv_n) begin
        adv_run++;
        lat_addr = bus_out;
        if (adv_run == 1) chk(!mem_cs_n && bus_oe, "R2 cs/bus with strobe", {mem_cs_n, bus_oe}, 2'b01);
      end else if (!p_adv) begin
        chk(adv_run == E_LOW, "R2 strobe width", adv_run, E_LOW);
        adv_run = 0; in_hold = 1; hold_run = 0;
      end
      if (in_hold) begin
        if (bus_oe && mem_we_n && !mem_cs_n) begin
          hold_run++;
          if (bus_out != lat_addr) chk(0, "R3 address hold value", bus_out, lat_addr);
        end else begin
          chk(hold_run == E_HOLD, "R3 hold width", hold_run, E_HOLD);
          in_hold = 0;
        end
      end
      if (!mem_we_n) begin
        we_run++;
        if (!mem_oe_n || !bus_oe) chk(0, "R4 oe high and bus driven in write", {mem_oe_n, bus_oe}, 2'b11);
      end else if (!p_we) begin
        chk(we_run == E_WR, "R4 write pulse width", we_run, E_WR);
        chk(mem_cs_n && !bus_oe, "R4 write end cs/bus", {mem_cs_n, bus_oe}, 2'b10);
        if (!p_be[0]) model_mem[lat_addr[7:0]][7:0]  = p_bus[7:0];
        if (!p_be[1]) model_mem[lat_addr[7:0]][15:8] = p_bus[15:8];
        we_run = 0;
      end
      if (mem_be_n != 2'b11 && mem_we_n && mem_oe_n)
        chk(0, "R5 byte enable outside data phase", mem_be_n, 2'b11);
      if (!mem_oe_n) begin
        oe_run++;
        if (bus_oe) chk(0, "R10 contention", bus_oe, 0);
      end else if (!p_oe) begin
        chk(oe_run == E_ACC, "R6 output-enable width", oe_run, E_ACC);
        oe_run = 0; turn_on = 1; turn_cnt = 1;
      end else if (turn_on) begin
        if (bus_oe) begin
          chk(turn_cnt >= E_TURN, "R7 turnaround", turn_cnt, E_TURN);
          turn_on = 0;
        end else begin
          if (!mem_cs_n && turn_cnt <= E_TURN) chk(0, "R7 cs high in turnaround", mem_cs_n, 1);
          turn_cnt++;
        end
      end
      if (rsp_done && p_done) chk(0, "R8 done longer than one cycle", 2, 1);
      p_adv = mem_adv_n; p_we = mem_we_n; p_oe = mem_oe_n; p_done = rsp_done;
      p_bus = bus_out; p_be = mem_be_n;
    end
  end

  int prev_acc = -1000, prev_ph = 0;

  // Starts and ends on a falling edge; back-to-back when called again at once.
  task automatic txn(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                     input logic [1:0] m, input bit b2b);
    int n, acc, ph;
    logic [15:0] lm;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 0;
    chk(!req_ready, "R9 ready low after accept", req_ready, 0);
    if (b2b)
      chk(acc - prev_acc == mx(E_WC, prev_ph + 1), "R9 back-to-back spacing",
          acc - prev_acc, mx(E_WC, prev_ph + 1));
    else
      chk(acc - prev_acc >= E_WC, "R9 minimum spacing", acc - prev_acc, E_WC);
    ph = wr ? WR_PH : RD_PH;
    n = 1;
    while (!rsp_done && n < 200) begin @(negedge clk); n++; end
    chk(n == ph + 1, wr ? "R8 write done latency" : "R8 read done latency", n, ph + 1);
    lm = lanes(m);
    if (wr) shadow[a[7:0]] = (shadow[a[7:0]] & ~lm) | (wd & lm);
    else chk(rsp_rdata == (shadow[a[7:0]] & lm), "R6 R5 read data by lane",
             rsp_rdata, shadow[a[7:0]] & lm);
    prev_acc = acc; prev_ph = ph;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
      shadow[i]    = model_mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset levels
    chk({mem_adv_n, mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, bus_oe, rsp_done, req_ready}
        == 9'b1111_11_001, "R1 reset pin levels",
        {mem_adv_n, mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, bus_oe, rsp_done, req_ready},
        9'b1111_11_001);
    rst_n = 1;
    @(negedge clk);
    // Directed: full write, partial writes, masked reads, empty mask.
    txn(1, 16'h1234, 16'hbeef, 2'b11, 0);
    txn(0, 16'h1234, 16'h0000, 2'b11, 1);
    txn(1, 16'h0a40, 16'h77aa, 2'b01, 1);
    txn(0, 16'h0a40, 16'h0000, 2'b11, 1);
    txn(1, 16'h0a40, 16'h1155, 2'b10, 1);
    txn(0, 16'h0a40, 16'h0000, 2'b10, 1);
    txn(0, 16'h0a40, 16'h0000, 2'b01, 1);
    txn(1, 16'h00ff, 16'hffff, 2'b00, 1);
    txn(0, 16'h00ff, 16'h0000, 2'b11, 1);
    txn(0, 16'h00ff, 16'h0000, 2'b00, 1);
    repeat (4) @(negedge clk);
    txn(1, 16'h0001, 16'h8001, 2'b11, 0);
    // Constrained random mix with optional idle gaps.
    for (int k = 0; k < 60; k++) begin
      int gap;
      logic [15:0] a;
      gap = $urandom_range(0, 3);
      a = {$urandom_range(0, 255) > 128 ? 8'h3c : 8'h00, 8'($urandom_range(0, 15))};
      for (int g = 0; g < gap; g++) @(negedge clk);
      txn(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)), gap == 0);
    end
    for (int k = 0; k < 16; k++) txn(0, 16'(k), 16'h0, 2'b11, 1);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule